// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic-Logic Unit

This block is the arithmetic core of a simple load/store processor datapath. It is combinational. The main controller supplies a 2-bit operation class, and the instruction supplies its 6-bit function field. A small decoder turns these into a 4-bit operation code. The code then steers a 32-bit datapath that computes one of six functions: AND, OR, NOR, add, subtract and signed set-on-less-than.

The decode works in two levels. A memory-reference instruction needs an address sum, so its class forces addition. A compare-for-equality branch needs a difference, so its class forces subtraction. Only the register-to-register class reads the function field. The unit also raises a zero flag whenever the result is all zeros, and the branch logic downstream uses that flag to decide whether operands match. The operation code is driven out as well, so that neighbouring logic and the bench can observe the decode.

Top module: `alu_decoded`

## Requirements
- R1: The operation code encodes the function as follows: 4'b0000 AND, 4'b0001 OR, 4'b0010 add, 4'b0110 subtract, 4'b0111 set-on-less-than, 4'b1100 NOR. The result follows that encoding.
- R2: Class 2'b00 selects add (code 4'b0010) for every value of the function field.
- R3: Class 2'b01 selects subtract (code 4'b0110) for every value of the function field.
- R4: With class 2'b10, the function field selects the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b101010 set-on-less-than, 6'b100111 NOR.
- R5: With class 2'b10 and any function value not listed in R4, the operation is add.
- R6: Class 2'b11 selects add for every value of the function field.
- R7: Add and subtract wrap modulo 2^32. No carry or overflow is reported.
- R8: Set-on-less-than compares the operands as signed two's-complement values. It returns 1 in bit 0 when A < B and 0 otherwise, and bits 31..1 are always 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0. Under subtract, this means it is 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_class | input | 2 | Operation class from the main controller |
| func_field | input | 6 | Function field of the instruction |
| op_code | output | 4 | Decoded operation code |
| result | output | 32 | Computed result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The embedded assertions are checked on every evaluation. They cover these behaviours:
- the forced classes always yield add or subtract;
- the decoder never emits an undefined code;
- subtracting equal operands gives a zero result, and the zero flag tracks operand equality under subtract;
- every set bit of a NOR result lies outside both operands;
- set-on-less-than never sets an upper bit.

Only the bench scenarios can show the following:
- that each function value maps to the right operation;
- the default taken for unlisted function values;
- that signed ordering holds at the extreme values 0x80000000 and 0x7FFFFFFF;
- that sums wrap.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FUNC_W  = 6;

  typedef enum logic [CODE_W-1:0] {
    OPC_AND = 4'b0000,
    OPC_OR  = 4'b0001,
    OPC_ADD = 4'b0010,
    OPC_SUB = 4'b0110,
    OPC_SLT = 4'b0111,
    OPC_NOR = 4'b1100
  } opc_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM  = 2'b00,
    CLS_BEQ  = 2'b01,
    CLS_REG  = 2'b10,
    CLS_RSVD = 2'b11
  } cls_e;

  localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNC_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_opsel.sv
module alu_opsel
  import alu_dec_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  input  logic [FUNC_W-1:0]  fn_i,
  output opc_e               opc_o
);

  opc_e fn_opc;

  // Second level: function field lookup, unlisted codes fall back to add (R4, R5)
  always_comb begin
    unique case (fn_i)
      FN_ADD:  fn_opc = OPC_ADD;
      FN_SUB:  fn_opc = OPC_SUB;
      FN_AND:  fn_opc = OPC_AND;
      FN_OR:   fn_opc = OPC_OR;
      FN_NOR:  fn_opc = OPC_NOR;
      FN_SLT:  fn_opc = OPC_SLT;
      default: fn_opc = OPC_ADD;
    endcase
  end

  // First level: class forces or defers (R2, R3, R6)
  always_comb begin
    unique case (cls_e'(cls_i))
      CLS_BEQ: opc_o = OPC_SUB;
      CLS_REG: opc_o = fn_opc;
      default: opc_o = OPC_ADD;
    endcase
  end

  always_comb begin
    if (!$isunknown({cls_i, fn_i})) begin
      assert_mem_add_R2: assert (cls_i != 2'b00 || opc_o == OPC_ADD)
        else $error("class 00 did not give add");
      assert_beq_sub_R3: assert (cls_i != 2'b01 || opc_o == OPC_SUB)
        else $error("class 01 did not give subtract");
      assert_rsvd_add_R6: assert (cls_i != 2'b11 || opc_o == OPC_ADD)
        else $error("class 11 did not give add");
      assert_legal_code_R1: assert (opc_o inside {OPC_AND, OPC_OR, OPC_ADD,
                                                  OPC_SUB, OPC_SLT, OPC_NOR})
        else $error("undefined operation code");
    end
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] lt_o
);

  logic [W-1:0] b_eff;
  logic [W-1:0] diff;
  logic         signs_differ;
  logic         less;

  // one adder, operand inverted with carry-in for subtract; wraps (R7)
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};

  // signed compare without overflow flag: differing signs decide directly (R8)
  assign diff         = a_i - b_i;
  assign signs_differ = a_i[W-1] ^ b_i[W-1];
  assign less         = signs_differ ? a_i[W-1] : diff[W-1];
  assign lt_o         = {{(W-1){1'b0}}, less};

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      assert_sub_equal_zero_R9: assert (!(sub_i && a_i == b_i) || sum_o == '0)
        else $error("equal operands did not subtract to zero");
      assert_slt_upper_clear_R8: assert (lt_o[W-1:1] == '0)
        else $error("set-on-less-than upper bits not clear");
      assert_slt_equal_false_R8: assert (a_i != b_i || lt_o == '0)
        else $error("equal operands reported less-than");
    end
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign nor_o[i] = ~(a_i[i] | b_i[i]);
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_nor_disjoint_R1: assert ((nor_o & (a_i | b_i)) == '0)
        else $error("NOR set a bit present in an operand");
      assert_and_subset_R1: assert ((and_o & ~or_o) == '0)
        else $error("AND bit outside OR");
    end
  end

endmodule

// File: rtl/alu_decoded.sv
module alu_decoded
  import alu_dec_pkg::*;
(
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [1:0]  op_class,
  input  logic [5:0]  func_field,
  output logic [3:0]  op_code,
  output logic [31:0] result,
  output logic        zero
);

  opc_e              opc;
  logic [DATA_W-1:0] sum_w, lt_w, and_w, or_w, nor_w;

  alu_opsel u_opsel (
    .cls_i (op_class),
    .fn_i  (func_field),
    .opc_o (opc)
  );

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sub_i (opc == OPC_SUB),
    .sum_o (sum_w),
    .lt_o  (lt_w)
  );

  alu_bitwise #(.W(DATA_W)) u_bitwise (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .and_o (and_w),
    .or_o  (or_w),
    .nor_o (nor_w)
  );

  always_comb begin
    unique case (opc)
      OPC_AND: result = and_w;
      OPC_OR:  result = or_w;
      OPC_NOR: result = nor_w;
      OPC_SLT: result = lt_w;
      default: result = sum_w;
    endcase
  end

  assign op_code = opc;
  assign zero    = (result == '0);

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_class, func_field})) begin
      assert_zero_tracks_equal_R9: assert (op_code != OPC_SUB || zero == (opnd_a == opnd_b))
        else $error("zero flag disagrees with operand equality");
      assert_slt_bit_R8: assert (op_code != OPC_SLT || result[31:1] == '0)
        else $error("set-on-less-than drove upper bits");
    end
  end

endmodule

// File: tb/alu_decoded_test.sv
module alu_decoded_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [1:0]  cls;
  logic [5:0]  fn;
  logic [3:0]  code;
  logic [31:0] res;
  logic        zf;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu_decoded uut (
    .opnd_a(a), .opnd_b(b), .op_class(cls), .func_field(fn),
    .op_code(code), .result(res), .zero(zf)
  );

  // {class, func, a, b, expected result, expected code}
  localparam int NV = 12;
  localparam logic [107:0] VEC [NV] = '{
    {2'b00, 6'b101010, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 4'b0010}, // R2
    {2'b01, 6'b100000, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000, 4'b0110}, // R3 R9
    {2'b01, 6'b000000, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 4'b0110}, // R3
    {2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'b0010}, // R7
    {2'b10, 6'b100010, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 4'b0110}, // R7
    {2'b10, 6'b100100, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 4'b0000}, // R4
    {2'b10, 6'b100101, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0, 4'b0001}, // R4
    {2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 4'b0111}, // R8
    {2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 4'b0111}, // R8
    {2'b10, 6'b100111, 32'h0F0F_0F0F, 32'h3030_3030, 32'hC0C0_C0C0, 4'b1100}, // R4
    {2'b10, 6'b111111, 32'h0000_0002, 32'h0000_0003, 32'h0000_0005, 4'b0010}, // R5
    {2'b11, 6'b100010, 32'h0000_000A, 32'h0000_0014, 32'h0000_001E, 4'b0010}  // R6
  };

  task automatic check(input string req, input logic [31:0] er, input logic [3:0] ec);
    tests++;
    if (res !== er || code !== ec || zf !== (er == 32'h0)) begin
      fails++;
      $display("FAIL %s: res=%h code=%b zero=%b expected res=%h code=%b zero=%b",
               req, res, code, zf, er, ec, (er == 32'h0));
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    cls = c; fn = f; a = x; b = y;
    #1;
  endtask

  function automatic logic [35:0] model(input logic [1:0] c, input logic [5:0] f,
                                        input logic [31:0] x, input logic [31:0] y);
    logic [3:0] k;
    logic [31:0] r;
    if (c == 2'b01) k = 4'b0110;
    else if (c != 2'b10) k = 4'b0010;
    else if (f == 6'b100010) k = 4'b0110;
    else if (f == 6'b100100) k = 4'b0000;
    else if (f == 6'b100101) k = 4'b0001;
    else if (f == 6'b100111) k = 4'b1100;
    else if (f == 6'b101010) k = 4'b0111;
    else k = 4'b0010;
    case (k)
      4'b0000: r = x & y;
      4'b0001: r = x | y;
      4'b1100: r = ~(x | y);
      4'b0110: r = x - y;
      4'b0111: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: r = x + y;
    endcase
    return {k, r};
  endfunction

  localparam logic [31:0] CORNER [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                         32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001};
  localparam logic [7:0] PAIRS [9] = '{
    {2'b00, 6'b100100}, {2'b01, 6'b100101}, {2'b10, 6'b100000}, {2'b10, 6'b100010},
    {2'b10, 6'b100100}, {2'b10, 6'b100101}, {2'b10, 6'b101010}, {2'b10, 6'b100111},
    {2'b11, 6'b000011}};

  initial begin
    cls = 2'b00; fn = 6'b0; a = 32'h0; b = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset-state", 32'h0, 4'b0010);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][107:106], VEC[i][105:100], VEC[i][99:68], VEC[i][67:36]);
      check("R1 R4 vector", VEC[i][35:4], VEC[i][3:0]);
    end

    // every class/function pair on random and corner operands (R1 R4 R7 R8)
    for (int p = 0; p < 9; p++) begin
      for (int n = 0; n < 40; n++) begin
        logic [31:0] x, y;
        logic [35:0] m;
        x = (n < 6) ? CORNER[n] : $urandom();
        y = (n < 6) ? CORNER[5 - n] : ((n % 3 == 0) ? x : $urandom());
        apply(PAIRS[p][7:6], PAIRS[p][5:0], x, y);
        m = model(PAIRS[p][7:6], PAIRS[p][5:0], x, y);
        check("R1 random", m[31:0], m[35:32]);
      end
    end

    // forced classes ignore the function field (R2 R3 R6)
    for (int f = 0; f < 64; f++) begin
      apply(2'b00, 6'(f), 32'h1234_0000, 32'h0000_5678);
      check("R2 forced add", 32'h1234_5678, 4'b0010);
      apply(2'b01, 6'(f), 32'h0000_0010, 32'h0000_0010);
      check("R3 forced sub", 32'h0, 4'b0110);
      apply(2'b11, 6'(f), 32'h8000_0000, 32'h8000_0000);
      check("R6 rsvd add wraps R7", 32'h0, 4'b0010);
    end

    // unlisted function codes default to add (R5)
    apply(2'b10, 6'b000000, 32'd7, 32'd8);  check("R5 default", 32'd15, 4'b0010);
    apply(2'b10, 6'b100011, 32'd7, 32'd8);  check("R5 default", 32'd15, 4'b0010);
    apply(2'b10, 6'b101011, 32'd7, 32'd8);  check("R5 default", 32'd15, 4'b0010);
    // signed compare edges (R8)
    apply(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0);  check("R8 -1<0", 32'd1, 4'b0111);
    apply(2'b10, 6'b101010, 32'h5, 32'h5);          check("R8 equal", 32'd0, 4'b0111);
    // zero flag with non-subtract op (R9)
    apply(2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555); check("R9 and-zero", 32'h0, 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule